// File: doc/BRIEF.md
# Register-Driven MDIO Management Master

This block lets a host processor reach the management registers of a SerDes or PHY over a two-wire MDC/MDIO link. The host sees two 32-bit registers. A setup register holds the MDC divisor, a preamble enable bit and a read-only completion flag. A frame register holds the complete 32-bit management frame: start code, opcode, PHY address, register address, turnaround and 16 data bits. When the host writes the frame register with the start bit set, the block shifts that word onto the wire exactly as written, most significant bit first. It can send a run of 32 ones first. For a read, the block releases the data line at the turnaround and collects the 16 bits that the PHY returns into the low half of the frame register.

The host writes the setup register, then writes a frame word with bit 30 set. After a short delay it polls the completion flag. Writing all zeros to bits 7:0 of the setup register turns the link off. MDC stops at low, MDIO is released, and any frame in flight is abandoned.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both registers read zero, MDC is low and the MDIO output enable is low.
- R2: Setup register layout: bits 6:0 are the divisor, bit 7 is preamble enable, bit 8 is the read-only completion flag and reads as zero otherwise. A host write to bit 8 has no effect. All other bits read zero.
- R3: While a frame runs, every MDC high phase and low phase lasts divisor+1 system clocks. A divisor of 0 gives 2 clocks. MDC rests low when no frame runs.
- R4: With preamble enable set, MDIO carries 32 consecutive ones on 32 MDC periods before the first frame bit.
- R5: The frame word goes out bit 31 first, down to bit 0, one bit per MDC period. Each bit changes only while MDC is low and is stable at the rising edge.
- R6: A frame with bit 29 set is a read. The output enable drops from frame bit 17 onward. The input is sampled on the rising MDC edges of frame bits 15..0, and the first sample goes to bit 15 of the frame register. Bits 31:16 keep their written value.
- R7: A frame with bit 29 clear keeps the output enable high for all 32 frame bits. The frame register keeps the written word.
- R8: The completion flag stays clear while a frame runs and is set only after the last MDC period has ended. A new start clears it.
- R9: A frame register write while a frame runs is ignored. It neither changes the register nor launches a frame.
- R10: Writing the setup register with bits 7:0 all zero stops MDC, releases MDIO and abandons a running frame, leaving the flag clear. While bits 7:0 are zero, a start write launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the setup register, 1 selects the frame register |
| reg_wdata | input | 32 | Write data |
| ctrl_rdata | output | 32 | Setup register read value |
| data_rdata | output | 32 | Frame register read value |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
The bench runs a model PHY that records every rising MDC edge and feeds read data after each falling edge. It drives one-heavy, zero-heavy and alternating read patterns, so a capture that is off by one bit, reversed, or taken on the wrong edge shows up as a shifted or mirrored value. A divisor of 0 is exercised, because a divider that takes it literally would stall or produce a one-clock half period. A data write during a busy frame checks that the frame is not corrupted and no second frame starts. A zero setup write in mid-frame checks that MDC stops at once and the flag does not claim completion. The bench also checks that the flag clears on a new start, which would fail if it stayed stale.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
    localparam int FRAME_W   = 32;
    localparam int PRE_LEN   = 32;
    localparam int RD_W      = 16;
    localparam int DIV_W     = 7;
    localparam int TA_POS    = 17;
    localparam int PRE_BIT   = 7;
    localparam int DONE_BIT  = 8;
    localparam int RD_BIT    = 29;
    localparam int START_BIT = 30;

    typedef enum logic {
        SEL_SETUP = 1'b0,
        SEL_FRAME = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
    parameter int DIV_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_d, cnt_q;
    logic [DIV_W-1:0] eff_div;

    always_comb begin
        eff_div = (div == '0) ? DIV_W'(1) : div;
        tick    = run && (cnt_q >= eff_div);
        cnt_d   = (!run || tick) ? '0 : cnt_q + DIV_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
    parameter int FRAME_W = 32,
    parameter int PRE_LEN = 32,
    parameter int RD_W    = 16,
    parameter int RD_BIT  = 29,
    parameter int TA_POS  = 17
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               abort,
    input  logic               pre_en,
    input  logic               tick,
    input  logic               mdio_i,
    input  logic [FRAME_W-1:0] frame,
    output logic               busy,
    output logic               mdc,
    output logic               mdio_o,
    output logic               mdio_oe,
    output logic               done_p,
    output logic [RD_W-1:0]    rd_data
);
    localparam int CNT_W = $clog2(PRE_LEN > FRAME_W ? PRE_LEN : FRAME_W);
    localparam logic [CNT_W-1:0] PRE_LAST  = CNT_W'(PRE_LEN - 1);
    localparam logic [CNT_W-1:0] FRM_LAST  = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] RD_FIRST  = CNT_W'(FRAME_W - RD_W);
    localparam logic [CNT_W-1:0] REL_FIRST = CNT_W'(FRAME_W - 1 - TA_POS);

    typedef struct packed {
        logic               busy;
        logic               mdc;
        logic               in_pre;
        logic               rd;
        logic               done;
        logic [CNT_W-1:0]   cnt;
        logic [FRAME_W-1:0] sh;
        logic [RD_W-1:0]    cap;
    } eng_t;

    eng_t q, d;

    always_comb begin
        d      = q;
        d.done = 1'b0;
        if (abort) begin
            d.busy   = 1'b0;
            d.mdc    = 1'b0;
            d.in_pre = 1'b0;
        end else if (start && !q.busy) begin
            d.busy   = 1'b1;
            d.mdc    = 1'b0;
            d.in_pre = pre_en;
            d.rd     = frame[RD_BIT];
            d.cnt    = '0;
            d.sh     = frame;
            d.cap    = '0;
        end else if (q.busy && tick) begin
            if (!q.mdc) begin
                d.mdc = 1'b1;
                if (q.rd && !q.in_pre && q.cnt >= RD_FIRST)
                    d.cap = {q.cap[RD_W-2:0], mdio_i};
            end else begin
                d.mdc = 1'b0;
                if (q.in_pre) begin
                    if (q.cnt == PRE_LAST) begin
                        d.in_pre = 1'b0;
                        d.cnt    = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end else begin
                    d.sh = {q.sh[FRAME_W-2:0], 1'b0};
                    if (q.cnt == FRM_LAST) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy    = q.busy;
    assign mdc     = q.mdc;
    assign mdio_o  = q.busy && (q.in_pre || q.sh[FRAME_W-1]);
    assign mdio_oe = q.busy && !(q.rd && !q.in_pre && q.cnt >= REL_FIRST);
    assign done_p  = q.done;
    assign rd_data = q.cap;

    // R3: MDC only moves on a divider tick or an abort
    assert_mdc_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy && !tick && !abort |=> $stable(q.mdc));

    // R8: completion is flagged right as the final high phase ends
    assert_done_after_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.done) |-> !q.mdc && $past(q.mdc) && !q.busy);
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic        reg_sel,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [31:0] data_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    typedef struct packed {
        logic [DIV_W-1:0]   div;
        logic               pre;
        logic               done;
        logic [FRAME_W-1:0] data;
    } regs_t;

    regs_t r_d, r_q;

    logic            busy, tick, done_p, start, abort, enabled;
    logic            wr_setup, wr_frame;
    logic [RD_W-1:0] rd_data;

    always_comb begin
        wr_setup = reg_wr && (reg_sel == SEL_SETUP);
        wr_frame = reg_wr && (reg_sel == SEL_FRAME);
        enabled  = (r_q.div != '0) || r_q.pre;
        abort    = wr_setup && (reg_wdata[PRE_BIT:0] == '0);
        start    = wr_frame && reg_wdata[START_BIT] && enabled && !busy;

        r_d = r_q;
        if (wr_setup) begin
            r_d.div = reg_wdata[DIV_W-1:0];
            r_d.pre = reg_wdata[PRE_BIT];
        end
        if (wr_frame && !busy) r_d.data = reg_wdata[FRAME_W-1:0];
        if (start)             r_d.done = 1'b0;
        if (done_p) begin
            r_d.done = 1'b1;
            if (r_q.data[RD_BIT]) r_d.data[RD_W-1:0] = rd_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    mdio_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .div   (r_q.div),
        .tick  (tick)
    );

    mdio_frame_engine #(
        .FRAME_W (FRAME_W),
        .PRE_LEN (PRE_LEN),
        .RD_W    (RD_W),
        .RD_BIT  (RD_BIT),
        .TA_POS  (TA_POS)
    ) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .abort   (abort),
        .pre_en  (r_q.pre),
        .tick    (tick),
        .mdio_i  (mdio_i),
        .frame   (reg_wdata[FRAME_W-1:0]),
        .busy    (busy),
        .mdc     (mdc),
        .mdio_o  (mdio_o),
        .mdio_oe (mdio_oe),
        .done_p  (done_p),
        .rd_data (rd_data)
    );

    assign ctrl_rdata = {{(32-DONE_BIT-1){1'b0}}, r_q.done, r_q.pre, r_q.div};
    assign data_rdata = r_q.data;

    // R9: a frame write during a running frame leaves the stored frame alone
    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy && wr_frame |=> $stable(r_q.data[FRAME_W-1:RD_W]));

    // R10: disabling the link idles the wire on the next cycle
    assert_disable_idles_R10: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !mdc && !mdio_oe && !busy);

    // R8: a start clears the completion flag
    assert_start_clears_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !r_q.done);
endmodule

// File: tb/mdio_mgmt_master_test.sv
module mdio_mgmt_master_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata, data_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b0;

    always #4 clk = ~clk;

    mdio_mgmt_master uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .ctrl_rdata(ctrl_rdata), .data_rdata(data_rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit summary_done = 1'b0;

    // model PHY / wire monitor
    int          rise_cnt = 0;
    int          base = 0;
    int          prelen = 0;
    logic [15:0] rd_pat = '0;
    logic [63:0] cap_bits = '0;
    logic [63:0] cap_oe = '0;
    int          cyc = 0;
    int          hi_start = 0;
    int          hi_len = 0;
    logic        prev_mdc = 1'b0;

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (mdc && !prev_mdc) begin
            rise_cnt <= rise_cnt + 1;
            cap_bits <= {cap_bits[62:0], mdio_o};
            cap_oe   <= {cap_oe[62:0], mdio_oe};
            hi_start <= cyc;
        end else if (!mdc && prev_mdc) begin
            int j;
            hi_len <= cyc - hi_start;
            j = rise_cnt - base - prelen;
            if (j >= 16 && j < 32) mdio_i <= rd_pat[31-j];
            else                   mdio_i <= 1'b0;
        end
        prev_mdc <= mdc;
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] v);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = v;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic wait_done(input string tag);
        int k;
        for (k = 0; k < 20000 && ctrl_rdata[8] !== 1'b1; k++) @(negedge clk);
        if (ctrl_rdata[8] !== 1'b1) chk({tag, " completion timeout"}, 0, 1);
        @(negedge clk);
    endtask

    // {pre, div, frame word, read pattern}
    localparam logic [55:0] VECS [0:4] = '{
        {1'b0, 7'd2, 32'h5002_ABCD, 16'h0000},
        {1'b1, 7'd1, 32'h6002_0000, 16'hA5C3},
        {1'b0, 7'd5, 32'h6FFE_0000, 16'h8001},
        {1'b1, 7'd0, 32'h5196_1234, 16'h0000},
        {1'b0, 7'd3, 32'h6FFE_0000, 16'h7FFE}
    };

    initial begin
        #(8 * 190000);
        if (!summary_done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 setup reg", ctrl_rdata, 0);
        chk("R1 frame reg", data_rdata, 0);
        chk("R1 mdc", mdc, 0);
        chk("R1 oe", mdio_oe, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        foreach (VECS[i]) begin
            logic       pre;
            logic [6:0] dv;
            logic [31:0] w;
            logic [15:0] pat;
            int eff;
            {pre, dv, w, pat} = VECS[i];
            eff = (dv == 0) ? 1 : dv;
            prelen = pre ? 32 : 0;
            base = rise_cnt;
            rd_pat = pat;
            wr(1'b0, {24'd0, pre, dv});
            chk("R2 setup readback", ctrl_rdata[7:0], {pre, dv});
            wr(1'b1, w);
            repeat (10) @(negedge clk);
            chk("R8 flag clear mid-frame", ctrl_rdata[8], 0);
            wait_done("R8");
            chk("R5 period count", rise_cnt - base, 32 + prelen);
            chk("R3 half period", hi_len, eff + 1);
            chk("R3 mdc idle low", mdc, 0);
            if (pre) chk("R4 preamble ones", cap_bits[63:32], 64'hFFFF_FFFF);
            if (w[29]) begin
                chk("R5 read header bits", cap_bits[31:18], w[31:18]);
                chk("R6 oe pattern", cap_oe[31:0], {14'h3FFF, 18'h0});
                chk("R6 captured data", data_rdata, {w[31:16], pat});
            end else begin
                chk("R5 write frame bits", cap_bits[31:0], w);
                chk("R7 oe pattern", cap_oe[31:0], 32'hFFFF_FFFF);
                chk("R7 frame reg kept", data_rdata, w);
            end
        end

        // R8: new start clears the flag
        chk("R8 flag set before restart", ctrl_rdata[8], 1);
        prelen = 0; base = rise_cnt;
        wr(1'b0, 32'h0000_0002);
        wr(1'b1, 32'h5002_1111);
        chk("R8 flag cleared by start", ctrl_rdata[8], 0);
        // R9: write during frame ignored
        repeat (20) @(negedge clk);
        wr(1'b1, 32'h6AAA_5555);
        wait_done("R9");
        chk("R9 frame reg unchanged", data_rdata, 32'h5002_1111);
        chk("R9 wire bits unchanged", cap_bits[31:0], 32'h5002_1111);
        repeat (300) @(negedge clk);
        chk("R9 no second frame", rise_cnt - base, 32);

        // R10: abort mid-frame
        base = rise_cnt;
        wr(1'b0, 32'h0000_0004);
        wr(1'b1, 32'h5002_2222);
        repeat (40) @(negedge clk);
        wr(1'b0, 32'h0000_0000);
        chk("R10 mdc stopped", mdc, 0);
        chk("R10 mdio released", mdio_oe, 0);
        begin
            int r0;
            r0 = rise_cnt;
            repeat (200) @(negedge clk);
            chk("R10 no edges after disable", rise_cnt - r0, 0);
        end
        chk("R10 flag clear after abort", ctrl_rdata[8], 0);
        // R10: start while disabled
        begin
            int r1;
            r1 = rise_cnt;
            wr(1'b1, 32'h5002_3333);
            repeat (200) @(negedge clk);
            chk("R10 disabled start idle", rise_cnt - r1, 0);
            chk("R10 disabled start oe", mdio_oe, 0);
            chk("R10 disabled flag", ctrl_rdata[8], 0);
        end

        // R2: flag bit not writable, upper bits read zero
        wr(1'b0, 32'hFFFF_FFFF);
        chk("R2 read-only flag", ctrl_rdata, 32'h0000_00FF);

        summary_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule